// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between a two-wire serial bus and a byte-wide memory engine holding 512 bytes. It samples the bus clock and data lines with a faster system clock. It finds start and stop conditions and shifts bytes in and out, most significant bit first. It acknowledges by enabling an open-drain pull-down on the data line. It decodes the address byte and steps through single-byte writes, page writes, reads at the current address, random reads and sequential reads. Write bytes and read requests go to the memory engine, which answers reads combinationally on `mem_rdata_i`.

The address byte carries a fixed four-bit type code and two strap bits that select the device. One more bit serves as the ninth memory address bit and is not part of the device select. A stop that closes a write transfer tells the engine to begin its internal write. While the engine reports that write as busy, the block does not acknowledge its own address, so a host can poll for the end of the write.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the data-line pull-down is off, no memory write, read or commit strobe is active, and a write strobe and a read strobe are never active in the same cycle.
- R2: Bus activity is ignored until a start condition is seen, which is the data line falling while the clock line is high. A stop condition is the data line rising while the clock line is high. An address byte clocked without a preceding start gets no acknowledge.
- R3: An address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..2 equal `sel_i[1:0]`. Bit 1 is not compared. Bit 0 selects read (1) or write (0).
- R4: For an acknowledged byte, the pull-down is on for the whole high time of the ninth clock and is released after the following clock fall.
- R5: In a write, bit 1 of the address byte and the next received byte form the 9-bit memory address {bit1, byte}. Each following data byte raises `mem_we_o` for one cycle with that address and the byte on `mem_wdata_o`.
- R6: Within one write transfer, each data byte after the first goes to the next address. Only the low `PAGE_BITS` bits count, wrapping within the page, and the upper bits stay fixed.
- R7: A stop that ends a write transfer in which at least one data byte was received raises `wr_commit_o` for exactly one cycle. Any other stop leaves it low.
- R8: While `wr_busy_i` is high, a matching address byte is not acknowledged.
- R9: A repeated start after the word address byte, with no stop in between, begins a read from that address. Read data is shifted out MSB first, and the block changes the data line only while the clock line is low.
- R10: A read that starts without a word address returns the byte that follows the last byte read or written.
- R11: When the host acknowledges a read byte, the next byte follows. The address wraps from 511 to 0.
- R12: When the host does not acknowledge a read byte, the block leaves the data line released until the next start or stop.
- R13: A start or stop in the middle of a byte ends the current transfer without any memory write. The block then accepts a new transfer normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sel_i | input | 2 | Strap value compared with address bits 3..2 |
| wr_busy_i | input | 1 | Memory engine is running an internal write |
| mem_rdata_i | input | 8 | Read byte from the engine for `mem_addr_o` (combinational) |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 drives low) |
| mem_addr_o | output | 9 | Current memory address |
| mem_wdata_o | output | 8 | Write byte, valid with `mem_we_o` |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read strobe; the byte at `mem_addr_o` is taken |
| wr_commit_o | output | 1 | One-cycle pulse telling the engine to start its internal write |

## Verification
The bound assertions check several rules on every cycle. The pull-down may only switch on while the clock line is low. Write and read strobes never overlap. The commit strobe lasts one cycle. A start always clears the bit counter and the pull-down. The pull-down is off while idle and while a write byte is being taken. Address matching, the page wrap, the read-address rollover, refusal while busy and silence after a host not-acknowledge depend on whole bus sequences, so only the directed scenarios show them. Those scenarios compare acknowledge bits, strobed addresses and data, and serial read bytes with values worked out from the requirements.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_ACKW, ST_ACK,
      ST_TX, ST_RACKW, ST_RACK, ST_RLOAD, ST_WAIT
   } tw_state_e;

   typedef enum logic [1:0] {K_DEV, K_WADDR, K_WDATA} tw_kind_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // data edges count as conditions only while the clock is high in both samples
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
   parameter int AW = 9,
   parameter int PB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_page,
   input  logic          inc_all,
   output logic [AW-1:0] addr
);
   if (PB < 1 || PB > AW) begin : g_bad_page
      $error("tw_addr_ctr: PB must lie in 1..AW");
   end

   logic [AW-1:0] nxt_page;

   if (PB == AW) begin : g_flat
      always_comb nxt_page = addr + AW'(1);
   end else begin : g_paged
      always_comb nxt_page = {addr[AW-1:PB], addr[PB-1:0] + PB'(1)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr <= '0;
      else if (load)     addr <= load_val;
      else if (inc_all)  addr <= addr + AW'(1);
      else if (inc_page) addr <= nxt_page;
   end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
   import tw_pkg::*;
#(
   parameter int         PAGE_BITS   = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] sel_i,
   input  logic       wr_busy_i,
   input  logic [7:0] mem_rdata_i,
   output logic       sda_oe_o,
   output logic [8:0] mem_addr_o,
   output logic [7:0] mem_wdata_o,
   output logic       mem_we_o,
   output logic       mem_re_o,
   output logic       wr_commit_o
);
   localparam int              BYTE_W   = 8;
   localparam int              ADDR_W   = BYTE_W + 1;
   localparam int              BCNT_W   = $clog2(BYTE_W);
   localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

   if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_bad_page
      $error("tw_mem_slave: PAGE_BITS must lie in 1..9");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   tw_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   tw_state_e          st;
   tw_kind_e           kind;
   logic [BCNT_W-1:0]  bcnt;
   logic [BYTE_W-2:0]  rx_sh;
   logic [BYTE_W-1:0]  tx_sh;
   logic [BYTE_W-1:0]  rx_byte;
   logic               rd_mode, hi_bit, wrote;
   logic               dev_match, byte_end;
   logic               ctr_load, load_tx;
   logic [ADDR_W-1:0]  ctr_addr;

   assign rx_byte   = {rx_sh, sda_s};
   assign byte_end  = scl_rise && (bcnt == LAST_BIT);
   assign dev_match = (rx_byte[7:4] == TYPE_CODE) && (rx_byte[3:2] == sel_i) && !wr_busy_i;
   assign ctr_load  = (st == ST_WADDR) && byte_end;
   assign load_tx   = scl_fall && ((st == ST_RLOAD) ||
                      ((st == ST_ACK) && (kind == K_DEV) && rd_mode));

   tw_addr_ctr #(.AW(ADDR_W), .PB(PAGE_BITS)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(ctr_load), .load_val({hi_bit, rx_byte}),
      .inc_page(mem_we_o), .inc_all(load_tx),
      .addr(ctr_addr));

   assign mem_addr_o = ctr_addr;
   assign mem_re_o   = load_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         kind        <= K_DEV;
         bcnt        <= '0;
         rx_sh       <= '0;
         tx_sh       <= '1;
         rd_mode     <= 1'b0;
         hi_bit      <= 1'b0;
         wrote       <= 1'b0;
         sda_oe_o    <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_wdata_o <= '0;
         wr_commit_o <= 1'b0;
      end else begin
         mem_we_o    <= 1'b0;
         wr_commit_o <= 1'b0;
         if (stop_det) begin
            st          <= ST_IDLE;
            sda_oe_o    <= 1'b0;
            bcnt        <= '0;
            wr_commit_o <= wrote;
            wrote       <= 1'b0;
         end else if (start_det) begin
            st       <= ST_DEV;
            sda_oe_o <= 1'b0;
            bcnt     <= '0;
            wrote    <= 1'b0;
         end else begin
            unique case (st)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_sh <= rx_byte[BYTE_W-2:0];
                     bcnt  <= bcnt + 1'b1;
                  end
                  if (byte_end) begin
                     if (st == ST_DEV) begin
                        kind <= K_DEV;
                        if (dev_match) begin
                           rd_mode <= rx_byte[0];
                           if (!rx_byte[0]) hi_bit <= rx_byte[1];
                           st <= ST_ACKW;
                        end else begin
                           st <= ST_WAIT;
                        end
                     end else if (st == ST_WADDR) begin
                        kind <= K_WADDR;
                        st   <= ST_ACKW;
                     end else begin
                        kind        <= K_WDATA;
                        mem_we_o    <= 1'b1;
                        mem_wdata_o <= rx_byte;
                        wrote       <= 1'b1;
                        st          <= ST_ACKW;
                     end
                  end
               end
               ST_ACKW: if (scl_fall) begin
                  sda_oe_o <= 1'b1;
                  st       <= ST_ACK;
               end
               ST_ACK, ST_RLOAD: if (scl_fall) begin
                  if (load_tx) begin
                     tx_sh    <= {mem_rdata_i[BYTE_W-2:0], 1'b1};
                     sda_oe_o <= ~mem_rdata_i[BYTE_W-1];
                     bcnt     <= '0;
                     st       <= ST_TX;
                  end else begin
                     sda_oe_o <= 1'b0;
                     st       <= (kind == K_DEV) ? ST_WADDR : ST_WDATA;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == LAST_BIT) st <= ST_RACKW;
                  end
                  if (scl_fall) begin
                     sda_oe_o <= ~tx_sh[BYTE_W-1];
                     tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b1};
                  end
               end
               ST_RACKW: if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  st       <= ST_RACK;
               end
               ST_RACK: if (scl_rise) begin
                  st <= sda_s ? ST_WAIT : ST_RLOAD;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
   import tw_pkg::*;
#(
   parameter int BCNT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_o,
   input logic              mem_we_o,
   input logic              mem_re_o,
   input logic              wr_commit_o,
   input tw_state_e         st,
   input logic              start_det,
   input logic [BCNT_W-1:0] bcnt
);
   a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe_o);

   a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> !sda_oe_o);

   a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |=> !wr_commit_o);

   a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_i);

   a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (bcnt == '0 && st == ST_DEV && !sda_oe_o));
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.BCNT_W(3)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .wr_commit_o(wr_commit_o),
   .st(st), .start_det(start_det), .bcnt(bcnt));

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;
   localparam int CLK_P = 10;
   localparam int Q     = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] sel = 2'b10;
   logic       busy = 1'b0;
   logic       sda_oe, we, re, commit;
   logic [8:0] addr;
   logic [7:0] wdata;
   logic [7:0] ram [512];
   wire        sda_bus = m_sda & ~sda_oe;
   wire  [7:0] rdata = ram[addr];

   int checks = 0, failures = 0, we_cnt = 0, commit_cnt = 0;
   logic [8:0] we_addr [8];
   logic [7:0] we_data [8];
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   tw_mem_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sel_i(sel), .wr_busy_i(busy), .mem_rdata_i(rdata),
      .sda_oe_o(sda_oe), .mem_addr_o(addr), .mem_wdata_o(wdata),
      .mem_we_o(we), .mem_re_o(re), .wr_commit_o(commit));

   function automatic logic [7:0] init_val(int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   always @(posedge clk) begin
      if (we) begin
         ram[addr] <= wdata;
         if (we_cnt < 8) begin
            we_addr[we_cnt] <= addr;
            we_data[we_cnt] <= wdata;
         end
         we_cnt <= we_cnt + 1;
      end
      if (commit) commit_cnt <= commit_cnt + 1;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic m_stop();
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic bit_w(logic b);
      m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
   endtask

   task automatic bit_r(output logic b);
      logic b2;
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq();
      b2 = sda_bus; m_scl = 1'b0; wq();
      if (b2 !== b) b = 1'bx;
   endtask

   task automatic byte_w(logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) bit_w(v[i]);
      bit_r(a);
      acked = (a === 1'b0);
   endtask

   task automatic byte_r(logic m_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) bit_r(v[i]);
      bit_w(!m_ack);
   endtask

   task automatic t_reset();
      chk("R1 oe", sda_oe, 0);
      chk("R1 strobes", {we, re, commit}, 0);
   endtask

   task automatic t_no_start();
      logic a;
      m_scl = 1'b0; wq();
      byte_w(8'hA8, a);
      chk("R2 no ack without start", a, 0);
      m_stop();
   endtask

   task automatic t_mismatch();
      logic a;
      m_start(); byte_w(8'hA4, a);
      chk("R3 select mismatch", a, 0);
      m_stop();
      m_start(); byte_w(8'h58, a);
      chk("R3 type mismatch", a, 0);
      m_stop();
   endtask

   task automatic t_byte_write();
      logic a;
      int w0 = we_cnt, c0 = commit_cnt;
      m_start(); byte_w(8'hAA, a);
      chk("R3 bit1 not compared, R4 dev ack", a, 1);
      byte_w(8'h23, a); chk("R4 word ack", a, 1);
      byte_w(8'h96, a); chk("R4 data ack", a, 1);
      chk("R5 one write", we_cnt - w0, 1);
      chk("R5 write addr", we_addr[w0], 9'h123);
      chk("R5 write data", we_data[w0], 8'h96);
      chk("R7 no commit before stop", commit_cnt - c0, 0);
      m_stop(); wq();
      chk("R7 commit on stop", commit_cnt - c0, 1);
   endtask

   task automatic t_page_write();
      logic a;
      int w0 = we_cnt, c0 = commit_cnt;
      m_start(); byte_w(8'hA8, a); byte_w(8'h0E, a);
      byte_w(8'h11, a); byte_w(8'h22, a); byte_w(8'h33, a);
      chk("R6 three writes", we_cnt - w0, 3);
      chk("R6 addr 0", we_addr[w0],     9'h00E);
      chk("R6 addr 1", we_addr[w0 + 1], 9'h00F);
      chk("R6 page wrap", we_addr[w0 + 2], 9'h000);
      chk("R6 data wrap", we_data[w0 + 2], 8'h33);
      m_stop(); wq();
      chk("R7 commit page", commit_cnt - c0, 1);
   endtask

   task automatic t_busy();
      logic a;
      busy = 1'b1;
      m_start(); byte_w(8'hA8, a);
      chk("R8 busy refuses", a, 0);
      m_stop();
      busy = 1'b0;
      m_start(); byte_w(8'hA8, a);
      chk("R8 idle accepts", a, 1);
      m_stop(); wq();
   endtask

   task automatic t_random_read();
      logic a;
      logic [7:0] v;
      int c0 = commit_cnt;
      m_start(); byte_w(8'hAA, a); byte_w(8'h23, a);
      m_start(); byte_w(8'hA9, a);
      chk("R9 read ack after repeated start", a, 1);
      byte_r(1'b0, v);
      chk("R9 random read data", v, 8'h96);
      m_stop(); wq();
      chk("R7 no commit after read", commit_cnt - c0, 0);
   endtask

   task automatic t_current_read();
      logic a;
      logic [7:0] v;
      m_start(); byte_w(8'hA9, a);
      byte_r(1'b0, v);
      chk("R10 current address read", v, init_val(9'h124));
      m_stop();
   endtask

   task automatic t_seq_read();
      logic a, b;
      logic [7:0] v;
      int hi = 0;
      m_start(); byte_w(8'hAA, a); byte_w(8'hFE, a);
      m_start(); byte_w(8'hA9, a);
      byte_r(1'b1, v); chk("R11 seq byte 0", v, init_val(9'h1FE));
      byte_r(1'b1, v); chk("R11 seq byte 1", v, init_val(9'h1FF));
      byte_r(1'b0, v); chk("R11 rollover to 0", v, 8'h33);
      for (int i = 0; i < 9; i++) begin
         bit_r(b);
         if (b === 1'b1) hi++;
      end
      chk("R12 released after nack", hi, 9);
      m_stop();
   endtask

   task automatic t_abort();
      logic a;
      int w0 = we_cnt, c0 = commit_cnt;
      m_start(); byte_w(8'hA8, a); byte_w(8'h40, a);
      for (int i = 0; i < 4; i++) bit_w(1'b0);
      m_stop(); wq();
      chk("R13 no write after mid-byte stop", we_cnt - w0, 0);
      chk("R13 no commit after abort", commit_cnt - c0, 0);
      m_start();
      bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
      m_start(); byte_w(8'hA8, a);
      chk("R13 accepted after mid-byte start", a, 1);
      m_stop(); wq();
   endtask

   initial begin
      for (int i = 0; i < 512; i++) ram[i] = init_val(i);
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      wq();
      t_reset();
      t_no_start();
      t_mismatch();
      t_byte_write();
      t_page_write();
      t_busy();
      t_random_read();
      t_current_read();
      t_seq_read();
      t_abort();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule